// File: doc/BRIEF.md
# Serial Audio Link Codec-Side Controller

This block is the codec end of a framed serial audio link. It runs from a master clock and makes the link bit clock by dividing that clock by two. It follows the frame strobe from the link controller and samples incoming serial data on falling bit-clock edges. It launches its own frame on rising edges. Each frame is 256 bit clocks long: a 16-bit tag slot, then twelve 20-bit slots, sent MSB first.

Slot 1 of the incoming frame carries a register address and slot 2 carries the write data. The block decodes one power-control register from these slots. Setting its power-down bit stops the link: the bit clock and the serial output are held low from the end of slot 2 onward. A long strobe pulse while the link is stopped is a warm restart, and it brings the clock back after a fixed delay. A cold reset restarts the link from scratch. If the strobe or the serial input is high when reset is released, both outputs go to high impedance until the next cold reset.

Top module: `audioLinkCodec`

## Requirements
- R1: While the link runs, `linkClk` is `mclk` divided by two: high for one `mclk` period, then low for one.
- R2: While `rstN` is low, `linkClk` and `serDataOut` are driven low. After `rstN` rises, `linkClk` stays low for START_DLY (4) full `mclk` periods and first goes high on the 5th `mclk` rising edge after the release.
- R3: `frameSync` and `serDataIn` are sampled only when `linkClk` falls. `serDataOut` changes only when `linkClk` rises.
- R4: The sample in which `frameSync` is first seen high is bit 0 of the incoming frame. Outgoing frame bit k is presented on the rising edge that follows incoming bit k. The outgoing tag (bits 0..15) is 0xE000. Outgoing slot 1 (bits 16..35) is {0, PD_ADDR (0x26), 12 zero bits}. Outgoing slot 2 (bits 36..55) holds the power-control register in its upper 16 bits, followed by 4 zero bits. All later bits are 0.
- R5: A write is accepted only when all of the following hold: incoming tag bits 15, 14 and 13 are all 1; slot 1 bit 19 (the read flag) is 0; and slot 1 bits 18:12 equal PD_ADDR. The accepted write loads slot 2 bits 19:4 into the power-control register. Any other frame leaves the register unchanged.
- R6: An accepted write with bit PD_BIT (12) set stops the link. `linkClk` never rises again after the falling edge that samples the last bit of slot 2, and `serDataOut` is low within two `mclk` periods of that edge. Both stay low until a warm restart.
- R7: Warm restart works only while the link is stopped. `frameSync` must be high for at least WARM_MIN (25) `mclk` rising edges and then go low. `linkClk` first rises on the 6th `mclk` rising edge after the strobe falls, and the power-down bit reads back as 0.
- R8: While the link is stopped, a `frameSync` pulse shorter than WARM_MIN edges is ignored and the clock stays stopped. While the link runs, `frameSync` pulses never stop or restart the clock.
- R9: If `frameSync` or `serDataIn` is high when `rstN` rises, `linkClk` and `serDataOut` are high impedance until `rstN` next goes low. A later reset released with both inputs low returns the block to normal driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, twice the bit clock rate |
| rstN | input | 1 | Active-low cold reset |
| frameSync | input | 1 | Frame strobe from the link controller; also the warm restart request |
| serDataIn | input | 1 | Serial frame data from the controller |
| linkClk | output | 1 | Bit clock; high impedance in test mode |
| serDataOut | output | 1 | Serial frame data to the controller; high impedance in test mode |

## Verification
Write frames are sent with different faults: a wrong address, the read flag set, and an invalid tag. After each one, the slot 2 readback in the next outgoing frame shows whether the decoder accepted or rejected the frame. Incoming bits change just after each rising edge, so a design that sampled on the wrong edge would decode shifted data. The clock stop and restart are timed in `mclk` edges from release or strobe fall. The run also includes a too-short strobe pulse while stopped, and a separate reset for each of the two test-mode straps. Pull-ups on the outputs make the high-impedance state visible as a steady 1 while the internal clock keeps toggling.

// File: rtl/linkPkg.sv
package linkPkg;
  localparam int TAG_W = 16;
  localparam int SLOT_W = 20;
  localparam int FRAME_BITS = 256;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {ST_WAIT, ST_RUN, ST_LOWPWR} ctrlState_t;

  typedef struct packed {
    logic rise;      // linkClk goes high at this mclk edge
    logic fall;      // linkClk goes low at this edge; inputs sampled
    logic clearOut;  // force serial output low now
    logic hold;      // link not running
  } linkStrobes_t;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } regWrite_t;
endpackage

// File: rtl/linkCtrl.sv
module linkCtrl
  import linkPkg::*;
#(
  parameter int START_DLY = 4,
  parameter int WARM_MIN = 25,
  parameter logic [ADDR_W-1:0] PD_ADDR = 7'h26,
  parameter int PD_BIT = 12
) (
  input  logic              mclk,
  input  logic              rstN,
  input  logic              syncIn,
  input  regWrite_t         wr,
  output logic              bitClkQ,
  output linkStrobes_t      stb,
  output logic [DATA_W-1:0] pdReg
);
  localparam int DLY_W = $clog2(START_DLY + 1);
  localparam int WARM_W = $clog2(WARM_MIN + 1);
  localparam logic [DLY_W-1:0] DLY_END = DLY_W'(START_DLY);
  localparam logic [WARM_W-1:0] WARM_END = WARM_W'(WARM_MIN);

  ctrlState_t state;
  logic [DLY_W-1:0] dlyCnt;
  logic [WARM_W-1:0] warmCnt;
  logic pdHit, enterLow, waitDone, warmDone;

  assign pdHit = wr.valid && (wr.addr == PD_ADDR) && (state == ST_RUN);
  assign enterLow = pdHit && wr.data[PD_BIT];
  assign waitDone = (state == ST_WAIT) && (dlyCnt == DLY_END);
  assign warmDone = (state == ST_LOWPWR) && !syncIn && (warmCnt == WARM_END);

  always_comb begin
    stb.rise = ((state == ST_RUN) && !bitClkQ && !enterLow) || waitDone;
    stb.fall = (state == ST_RUN) && bitClkQ;
    stb.clearOut = enterLow;
    stb.hold = (state != ST_RUN);
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_WAIT;
      bitClkQ <= 1'b0;
      dlyCnt <= '0;
      warmCnt <= '0;
      pdReg <= '0;
    end else begin
      if (pdHit) pdReg <= wr.data;
      case (state)
        ST_WAIT: begin
          if (waitDone) begin
            state <= ST_RUN;
            bitClkQ <= 1'b1;
            dlyCnt <= '0;
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (enterLow) begin
            state <= ST_LOWPWR;
            bitClkQ <= 1'b0;
          end else begin
            bitClkQ <= !bitClkQ;
          end
        end
        default: begin
          bitClkQ <= 1'b0;
          if (syncIn) begin
            if (warmCnt != WARM_END) warmCnt <= warmCnt + 1'b1;
          end else begin
            if (warmDone) begin
              state <= ST_WAIT;
              dlyCnt <= '0;
              pdReg[PD_BIT] <= 1'b0;
            end
            warmCnt <= '0;
          end
        end
      endcase
    end
  end

  assert_high_one_cycle_R1: assert property (@(posedge mclk) disable iff (!rstN)
    (state == ST_RUN && bitClkQ) |=> !bitClkQ);
  assert_wait_clock_low_R2: assert property (@(posedge mclk) disable iff (!rstN)
    (state == ST_WAIT && dlyCnt < DLY_END) |=> !bitClkQ);
  assert_write_after_fall_R5: assert property (@(posedge mclk) disable iff (!rstN)
    wr.valid |-> !bitClkQ);
  assert_lowpwr_clock_low_R6: assert property (@(posedge mclk) disable iff (!rstN)
    (state == ST_LOWPWR) |-> !bitClkQ);
  assert_run_never_restarts_R8: assert property (@(posedge mclk) disable iff (!rstN)
    (state == ST_RUN) |=> (state != ST_WAIT));
endmodule

// File: rtl/linkData.sv
module linkData
  import linkPkg::*;
#(
  parameter logic [ADDR_W-1:0] PD_ADDR = 7'h26
) (
  input  logic              mclk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic              serIn,
  input  linkStrobes_t      stb,
  input  logic [DATA_W-1:0] pdReg,
  output regWrite_t         wr,
  output logic              sdOutQ
);
  localparam int TAG_IW = $clog2(TAG_W);
  localparam int SLOT_IW = $clog2(SLOT_W);
  localparam logic [IDX_W-1:0] TAG_END = IDX_W'(TAG_W - 1);
  localparam logic [IDX_W-1:0] S1_END = IDX_W'(TAG_W + SLOT_W - 1);
  localparam logic [IDX_W-1:0] S2_END = IDX_W'(TAG_W + 2 * SLOT_W - 1);
  localparam logic [TAG_W-1:0] TAG_IMG = {3'b111, {(TAG_W - 3){1'b0}}};
  localparam logic [SLOT_W-1:0] S1_IMG = {1'b0, PD_ADDR, {(SLOT_W - ADDR_W - 1){1'b0}}};

  logic syncPrev, locked, frameStart, txBit;
  logic [IDX_W-1:0] rxIdx, curIdx, txIdx;
  logic [SLOT_W-2:0] rxShift;
  logic [SLOT_W-1:0] word, s2Img;
  logic [2:0] tagQ;
  logic [ADDR_W:0] slot1Q;

  assign frameStart = syncIn && !syncPrev;
  assign curIdx = frameStart ? '0 : rxIdx;
  assign word = {rxShift, serIn};
  assign s2Img = {pdReg, {(SLOT_W - DATA_W){1'b0}}};

  always_comb begin
    txBit = 1'b0;
    if (txIdx <= TAG_END) txBit = TAG_IMG[TAG_IW'(TAG_END - txIdx)];
    else if (txIdx <= S1_END) txBit = S1_IMG[SLOT_IW'(S1_END - txIdx)];
    else if (txIdx <= S2_END) txBit = s2Img[SLOT_IW'(S2_END - txIdx)];
  end

  // receive side: everything moves on the falling bit-clock edge
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      locked <= 1'b0;
      rxIdx <= '0;
      rxShift <= '0;
      tagQ <= '0;
      slot1Q <= '0;
      wr <= '0;
    end else begin
      wr.valid <= 1'b0;
      if (stb.fall) begin
        syncPrev <= syncIn;
        rxShift <= word[SLOT_W-2:0];
        rxIdx <= curIdx + 1'b1;
        if (frameStart) locked <= 1'b1;
        if (locked || frameStart) begin
          if (curIdx == TAG_END) tagQ <= word[TAG_W-1:TAG_W-3];
          if (curIdx == S1_END) slot1Q <= word[SLOT_W-1:SLOT_W-ADDR_W-1];
          if (curIdx == S2_END && tagQ == 3'b111 && !slot1Q[ADDR_W]) begin
            wr.valid <= 1'b1;
            wr.addr <= slot1Q[ADDR_W-1:0];
            wr.data <= word[SLOT_W-1:SLOT_W-DATA_W];
          end
        end
      end
    end
  end

  // transmit side: launch on the rising bit-clock edge
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      txIdx <= '0;
      sdOutQ <= 1'b0;
    end else if (stb.clearOut || stb.hold) begin
      sdOutQ <= 1'b0;
    end else if (stb.fall && frameStart) begin
      txIdx <= '0;
    end else if (stb.rise && locked) begin
      sdOutQ <= txBit;
      txIdx <= txIdx + 1'b1;
    end
  end

  assert_out_moves_on_rise_R3: assert property (@(posedge mclk) disable iff (!rstN)
    !(stb.rise || stb.clearOut || stb.hold) |=> $stable(sdOutQ));
  assert_no_sample_on_rise_R3: assert property (@(posedge mclk) disable iff (!rstN)
    stb.fall |-> !stb.rise);
  assert_idle_output_low_R6: assert property (@(posedge mclk) disable iff (!rstN)
    stb.hold |-> !sdOutQ);
endmodule

// File: rtl/audioLinkCodec.sv
module audioLinkCodec
  import linkPkg::*;
#(
  parameter int START_DLY = 4,
  parameter int WARM_MIN = 25,
  parameter logic [ADDR_W-1:0] PD_ADDR = 7'h26,
  parameter int PD_BIT = 12
) (
  input  logic mclk,
  input  logic rstN,
  input  logic frameSync,
  input  logic serDataIn,
  output logic linkClk,
  output logic serDataOut
);
  linkStrobes_t stb;
  regWrite_t wr;
  logic [DATA_W-1:0] pdReg;
  logic clkQ, sdOutQ, testMode, driveEn;

  // strap captured when reset is released; held until the next release
  always_ff @(posedge rstN) testMode <= frameSync | serDataIn;

  assign driveEn = !rstN || !testMode;
  assign linkClk = driveEn ? clkQ : 1'bz;
  assign serDataOut = driveEn ? sdOutQ : 1'bz;

  linkCtrl #(
    .START_DLY(START_DLY), .WARM_MIN(WARM_MIN), .PD_ADDR(PD_ADDR), .PD_BIT(PD_BIT)
  ) ctrl (
    .mclk(mclk), .rstN(rstN), .syncIn(frameSync), .wr(wr),
    .bitClkQ(clkQ), .stb(stb), .pdReg(pdReg)
  );

  linkData #(.PD_ADDR(PD_ADDR)) data (
    .mclk(mclk), .rstN(rstN), .syncIn(frameSync), .serIn(serDataIn),
    .stb(stb), .pdReg(pdReg), .wr(wr), .sdOutQ(sdOutQ)
  );

  assert_reset_drives_low_R2: assert property (@(posedge mclk)
    !rstN |-> (clkQ == 1'b0 && sdOutQ == 1'b0));
endmodule

// File: tb/audioLinkCodec_test.sv
`timescale 1ns/1ps
module audioLinkCodec_test;
  logic mclk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic serDataIn = 1'b0;
  wire linkW;
  wire outW;
  pullup (linkW);
  pullup (outW);

  int tests = 0;
  int fails = 0;
  int glitches = 0;
  bit done = 0;
  logic [0:255] outFrame;

  audioLinkCodec uut (
    .mclk(mclk), .rstN(rstN), .frameSync(frameSync), .serDataIn(serDataIn),
    .linkClk(linkW), .serDataOut(outW)
  );

  always #2.5 mclk = ~mclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic countToRise(output int n);
    n = 0;
    do begin
      @(posedge mclk); #1; n++;
    end while (linkW !== 1'b1 && n < 100);
  endtask

  task automatic coldReset(input logic strapSync, input logic strapData, input bit expectRun);
    int n;
    @(negedge mclk); rstN = 1'b0;
    repeat (5) @(negedge mclk);
    check("R2", {30'd0, linkW, outW}, 32'd0, "outputs during reset");
    frameSync = strapSync; serDataIn = strapData;
    repeat (25) @(negedge mclk);
    rstN = 1'b1;
    #2; frameSync = 1'b0; serDataIn = 1'b0;
    if (expectRun) begin
      countToRise(n);
      check("R2", n, 5, "mclk edges from release to first rise");
    end
  endtask

  task automatic sendFrame(input logic [15:0] tag, input logic [19:0] s1,
                           input logic [19:0] s2, input int nBits);
    logic [0:255] img;
    logic a;
    img = {tag, s1, s2, 200'd0};
    for (int k = 0; k < nBits; k++) begin
      @(posedge linkW); #1;
      frameSync = (k < 16);
      serDataIn = img[k];
      @(negedge linkW); #1;
      if (k > 0) outFrame[k-1] = outW;
      a = outW;
      #3;
      if (outW !== a) glitches++;
    end
    frameSync = 1'b0; serDataIn = 1'b0;
  endtask

  task automatic testReset;
    real t0, t1, t2;
    coldReset(1'b0, 1'b0, 1'b1);
    @(posedge linkW); t0 = $realtime;
    @(negedge linkW); t1 = $realtime;
    @(posedge linkW); t2 = $realtime;
    check("R1", int'((t1 - t0) * 10), 50, "high time x0.1ns");
    check("R1", int'((t2 - t0) * 10), 100, "period x0.1ns");
  endtask

  task automatic testFrameOut;
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R4", outFrame[0:15], 32'hE000, "outgoing tag");
    check("R4", outFrame[16:35], {12'd0, 1'b0, 7'h26, 12'h000}, "outgoing slot1");
    check("R4", outFrame[36:55], 32'h0, "outgoing slot2 after reset");
    check("R4", outFrame[56:87], 32'h0, "outgoing slot3/4");
  endtask

  task automatic testWrites;
    sendFrame(16'hE000, {1'b0, 7'h26, 12'h0}, {16'h0A5C, 4'h0}, 256);
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R5", outFrame[36:55], {12'd0, 16'h0A5C, 4'h0}, "accepted write readback");
    check("R3", glitches, 0, "serDataOut moved while clock low");
    sendFrame(16'hE000, {1'b0, 7'h24, 12'h0}, {16'h1111, 4'h0}, 256);
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R5", outFrame[36:55], {12'd0, 16'h0A5C, 4'h0}, "wrong address ignored");
    sendFrame(16'hE000, {1'b1, 7'h26, 12'h0}, {16'h2222, 4'h0}, 256);
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R5", outFrame[36:55], {12'd0, 16'h0A5C, 4'h0}, "read flag ignored");
    sendFrame(16'hA000, {1'b0, 7'h26, 12'h0}, {16'h3333, 4'h0}, 256);
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R5", outFrame[36:55], {12'd0, 16'h0A5C, 4'h0}, "invalid tag ignored");
    check("R8", {31'd0, linkW !== 1'bx}, 1, "clock still running after strobes");
  endtask

  task automatic watchStopped(input string req, input string what);
    int highs;
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge mclk); #1;
      if (linkW !== 1'b0 || outW !== 1'b0) highs++;
    end
    check(req, highs, 0, what);
  endtask

  task automatic testLowPower;
    int n;
    sendFrame(16'hE000, {1'b0, 7'h26, 12'h0}, {16'h1003, 4'h0}, 56);
    repeat (2) @(posedge mclk); #1;
    check("R6", {30'd0, linkW, outW}, 32'd0, "outputs after stop write");
    watchStopped("R6", "activity while stopped");
    @(negedge mclk); frameSync = 1'b1;
    repeat (10) @(negedge mclk); frameSync = 1'b0;
    watchStopped("R8", "short strobe woke link");
    @(negedge mclk); frameSync = 1'b1;
    repeat (30) @(negedge mclk); frameSync = 1'b0;
    countToRise(n);
    check("R7", n, 6, "mclk edges from strobe fall to first rise");
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R7", outFrame[36:55], {12'd0, 16'h0003, 4'h0}, "power-down bit cleared");
    check("R7", outFrame[0:15], 32'hE000, "frame after wake");
  endtask

  task automatic testStrap(input logic s, input logic d);
    int bad;
    coldReset(s, d, 1'b0);
    repeat (20) @(posedge mclk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge mclk); #1;
      if (linkW !== 1'b1 || outW !== 1'b1) bad++;
    end
    check("R9", bad, 0, "driven samples in test mode");
  endtask

  initial begin
    testReset();
    testFrameOut();
    testWrites();
    testLowPower();
    testStrap(1'b1, 1'b0);
    testStrap(1'b0, 1'b1);
    coldReset(1'b0, 1'b0, 1'b1);
    sendFrame(16'h0000, 20'h0, 20'h0, 256);
    check("R9", outFrame[0:15], 32'hE000, "normal frame after test mode ends");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule